// File: doc/BRIEF.md
# Class-Aware Route Computation for a Two-Layer Mesh Router

This unit picks the output port for a packet header at one router of a stacked mesh. The mesh has two layers of 4x4 nodes. Layer 0 holds the processor cores with their private caches. Layer 1 holds the shared last-level cache slices. Each node gives the unit its own coordinates and a header: the destination coordinates, the message class and a diverted flag. The unit answers with an output direction, a virtual-channel class and the updated diverted flag. The answer appears one clock after the header is presented.

The order in which the unit resolves the dimensions depends on the message class. Requests finish their layer change first, then Y, then X. Replies finish X first, then Y, then the layer change. Each class has its own virtual channel, so the two orders cannot form a dependency cycle.

A packet that travels between two core-layer nodes can be diverted upward when its normal planar link is short of credits. Once diverted, it crosses the cache layer to the destination column and then descends. After the descent it never makes another planar hop.

Top module: `rc_route3d`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high after that edge, and `out_port`, `out_vc` and `out_mis` reflect the inputs sampled at that edge. When `in_valid` is low at an edge, `out_valid` is low after it.
- R2: When the current coordinates equal the destination, the port is LOCAL (code 0), whatever the class, diverted flag or congestion.
- R3: A request (`msg_class`=0) that is not diverted moves in z first, then y, then x. Port codes are: XP=1 (x+1), XN=2 (x-1), YP=3 (y+1), YN=4 (y-1), UP=5 (z+1), DN=6 (z-1).
- R4: A reply (`msg_class`=1) that is not diverted moves in x first, then y, then z.
- R5: `out_vc` equals the message class (0 for request, 1 for reply), so the two classes never share a virtual channel.
- R6: An output port p (1..6) counts as congested only when its free-credit count, `port_credits[(p-1)*4 +: 4]`, is strictly below `cong_thresh`. A count equal to the threshold is not congested.
- R7: A header is diverted to UP with `out_mis`=1 when all of these hold: the current node and the destination are both on layer 0, the diverted flag is clear, the normal port is planar and congested, and UP is not congested.
- R8: When any condition of R7 fails, the normal port is kept and `out_mis` equals `mis_in`. In particular there is no diversion when UP is congested, when the node is on layer 1, or when the flag is already set.
- R9: A diverted header that is not at its destination goes UP while on layer 0. On layer 1 it moves in x, then y, then DN.
- R10: A packet that is never diverted reaches its destination in exactly |dx|+|dy|+|dz| hops. A diverted packet arrives in that count plus 2 hops and makes no planar hop after its DN hop.
- R11: During reset, `out_valid`, `out_port`, `out_vc` and `out_mis` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header present this cycle |
| cur_x | input | 2 | Current node x |
| cur_y | input | 2 | Current node y |
| cur_z | input | 1 | Current node layer |
| dst_x | input | 2 | Destination x |
| dst_y | input | 2 | Destination y |
| dst_z | input | 1 | Destination layer |
| msg_class | input | 1 | 0 request, 1 reply |
| mis_in | input | 1 | Diverted flag from the header |
| port_credits | input | 24 | Free credits, 4 bits per port, port p at bits (p-1)*4 |
| cong_thresh | input | 4 | Congestion threshold |
| out_valid | output | 1 | Decision valid |
| out_port | output | 3 | Selected output port code |
| out_vc | output | 1 | Virtual-channel class |
| out_mis | output | 1 | Updated diverted flag |

## Verification
A wrong dimension-order or diversion decision shows up one cycle later as an unexpected port code on the same header. Because the bench feeds each decision back as the next hop, a single bad step also changes the hop count or the final coordinates of the whole path. A diversion flag that is set or cleared wrongly shows on the next hop: the packet either climbs back up or makes a planar hop after descending. Every source and destination pair of both classes is walked, with and without planar congestion, so each wrong decision is caught on the first path that passes through it.

// File: rtl/rc_pkg.sv
package rc_pkg;

    parameter int MESH_X  = 4;
    parameter int MESH_Y  = 4;
    parameter int MESH_Z  = 2;
    parameter int CRED_W  = 4;
    parameter int NPORT   = 6;

    localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1;
    localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1;
    localparam int ZW = (MESH_Z > 1) ? $clog2(MESH_Z) : 1;
    localparam int PW = 3;

    typedef enum logic [PW-1:0] {
        P_LOCAL = 3'd0,
        P_XP    = 3'd1,
        P_XN    = 3'd2,
        P_YP    = 3'd3,
        P_YN    = 3'd4,
        P_UP    = 3'd5,
        P_DN    = 3'd6
    } port_e;

    typedef enum logic {
        CLS_REQ = 1'b0,
        CLS_REP = 1'b1
    } cls_e;

    typedef enum logic {
        ORD_ZYX = 1'b0,
        ORD_XYZ = 1'b1
    } order_e;

    typedef struct packed {
        logic [ZW-1:0] z;
        logic [YW-1:0] y;
        logic [XW-1:0] x;
    } coord_t;

    typedef struct packed {
        port_e port;
        logic  vc;
        logic  mis;
    } decision_t;

    function automatic port_e step_x(coord_t c, coord_t d);
        if (c.x < d.x)      return P_XP;
        else if (c.x > d.x) return P_XN;
        else                return P_LOCAL;
    endfunction

    function automatic port_e step_y(coord_t c, coord_t d);
        if (c.y < d.y)      return P_YP;
        else if (c.y > d.y) return P_YN;
        else                return P_LOCAL;
    endfunction

    function automatic port_e step_z(coord_t c, coord_t d);
        if (c.z < d.z)      return P_UP;
        else if (c.z > d.z) return P_DN;
        else                return P_LOCAL;
    endfunction

    function automatic logic is_planar(port_e p);
        return (p == P_XP) || (p == P_XN) || (p == P_YP) || (p == P_YN);
    endfunction

endpackage

// File: rtl/rc_congest.sv
module rc_congest
    import rc_pkg::*;
#(
    parameter int N_PORTS = NPORT,
    parameter int CW      = CRED_W
) (
    input  logic [N_PORTS*CW-1:0] credits,
    input  logic [CW-1:0]         thresh,
    output logic [N_PORTS-1:0]    cong
);

    genvar gi;
    generate
        for (gi = 0; gi < N_PORTS; gi++) begin : g_port
            assign cong[gi] = (credits[gi*CW +: CW] < thresh);
        end
    endgenerate

endmodule

// File: rtl/rc_dor.sv
module rc_dor
    import rc_pkg::*;
(
    input  coord_t cur,
    input  coord_t dst,
    input  order_e order,
    output port_e  port
);

    port_e px, py, pz;

    always_comb begin
        px = step_x(cur, dst);
        py = step_y(cur, dst);
        pz = step_z(cur, dst);
        if (order == ORD_ZYX) begin
            if (pz != P_LOCAL)      port = pz;
            else if (py != P_LOCAL) port = py;
            else                    port = px;
        end else begin
            if (px != P_LOCAL)      port = px;
            else if (py != P_LOCAL) port = py;
            else                    port = pz;
        end
    end

endmodule

// File: rtl/rc_divert.sv
module rc_divert
    import rc_pkg::*;
#(
    parameter int N_PORTS = NPORT
) (
    input  coord_t             cur,
    input  coord_t             dst,
    input  logic               mis_in,
    input  port_e              norm_port,
    input  logic [N_PORTS-1:0] cong,
    output port_e              sel_port,
    output logic               mis_out
);

    logic base_layer;
    logic at_dst;
    logic norm_cong;
    logic up_cong;
    logic may_divert;

    always_comb begin
        base_layer = (cur.z == '0) && (dst.z == '0);
        at_dst     = (cur == dst);
        norm_cong  = 1'b0;
        for (int i = 1; i <= N_PORTS; i++) begin
            if (int'(norm_port) == i) norm_cong = cong[i-1];
        end
        up_cong    = cong[int'(P_UP) - 1];
        may_divert = base_layer && !mis_in && !at_dst &&
                     is_planar(norm_port) && norm_cong && !up_cong;

        sel_port = norm_port;
        mis_out  = mis_in;
        if (at_dst) begin
            sel_port = P_LOCAL;
        end else if (mis_in && (cur.z == '0)) begin
            sel_port = P_UP;
        end else if (may_divert) begin
            sel_port = P_UP;
            mis_out  = 1'b1;
        end
    end

endmodule

// File: rtl/rc_route3d.sv
module rc_route3d
    import rc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [XW-1:0]           cur_x,
    input  logic [YW-1:0]           cur_y,
    input  logic [ZW-1:0]           cur_z,
    input  logic [XW-1:0]           dst_x,
    input  logic [YW-1:0]           dst_y,
    input  logic [ZW-1:0]           dst_z,
    input  logic                    msg_class,
    input  logic                    mis_in,
    input  logic [NPORT*CRED_W-1:0] port_credits,
    input  logic [CRED_W-1:0]       cong_thresh,
    output logic                    out_valid,
    output logic [PW-1:0]           out_port,
    output logic                    out_vc,
    output logic                    out_mis
);

    coord_t            cur_c, dst_c;
    order_e            order;
    port_e             norm_port, sel_port;
    logic [NPORT-1:0]  cong;
    logic              mis_nxt;
    decision_t         dec_q;

    assign cur_c = '{z: cur_z, y: cur_y, x: cur_x};
    assign dst_c = '{z: dst_z, y: dst_y, x: dst_x};

    // Diverted headers use x-then-y on the cache layer; otherwise the class decides.
    assign order = (mis_in || msg_class == CLS_REP) ? ORD_XYZ : ORD_ZYX;

    rc_congest #(.N_PORTS(NPORT), .CW(CRED_W)) u_cong (
        .credits (port_credits),
        .thresh  (cong_thresh),
        .cong    (cong)
    );

    rc_dor u_dor (
        .cur   (cur_c),
        .dst   (dst_c),
        .order (order),
        .port  (norm_port)
    );

    rc_divert #(.N_PORTS(NPORT)) u_div (
        .cur       (cur_c),
        .dst       (dst_c),
        .mis_in    (mis_in),
        .norm_port (norm_port),
        .cong      (cong),
        .sel_port  (sel_port),
        .mis_out   (mis_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dec_q     <= '{port: P_LOCAL, vc: 1'b0, mis: 1'b0};
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dec_q <= '{port: sel_port, vc: msg_class, mis: mis_nxt};
            end
        end
    end

    assign out_port = dec_q.port;
    assign out_vc   = dec_q.vc;
    assign out_mis  = dec_q.mis;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r2_local_at_dst: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur_x == dst_x && cur_y == dst_y && cur_z == dst_z)
        |=> out_port == P_LOCAL);
    a_r5_vc_is_class: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_vc == $past(msg_class));
    a_r8_no_divert_off_base: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (mis_in || cur_z != '0 || dst_z != '0))
        |=> out_mis == $past(mis_in));
    a_r7_divert_goes_up: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mis_in) |=> (!out_mis || out_port == P_UP));
    a_r9_no_climb_on_top: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mis_in && cur_z != '0) |=> out_port != P_UP);

endmodule

// File: tb/rc_route3d_tb.sv
module rc_route3d_tb;
    import rc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic                    in_valid = 1'b0;
    logic [XW-1:0]           cur_x = '0, dst_x = '0;
    logic [YW-1:0]           cur_y = '0, dst_y = '0;
    logic [ZW-1:0]           cur_z = '0, dst_z = '0;
    logic                    msg_class = 1'b0, mis_in = 1'b0;
    logic [NPORT*CRED_W-1:0] port_credits = '0;
    logic [CRED_W-1:0]       cong_thresh = '0;
    logic                    out_valid, out_vc, out_mis;
    logic [PW-1:0]           out_port;

    int n_cmp = 0;
    int n_bad = 0;

    rc_route3d u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
        .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z),
        .msg_class(msg_class), .mis_in(mis_in),
        .port_credits(port_credits), .cong_thresh(cong_thresh),
        .out_valid(out_valid), .out_port(out_port),
        .out_vc(out_vc), .out_mis(out_mis)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mask bit p marks port p as short of credits (credits 0 against threshold 2)
    task automatic set_cong(input logic [6:1] m);
        for (int p = 1; p <= 6; p++)
            port_credits[(p-1)*CRED_W +: CRED_W] = m[p] ? 4'd0 : 4'd10;
        cong_thresh = 4'd2;
    endtask

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    // Returns {mis, port} from the stated rules.
    function automatic logic [3:0] ref_route(int cx, int cy, int cz, int dx, int dy,
                                             int dz, bit cls, bit mis, logic [6:1] cg);
        int px, py, pz, p;
        px = (cx < dx) ? 1 : (cx > dx) ? 2 : 0;
        py = (cy < dy) ? 3 : (cy > dy) ? 4 : 0;
        pz = (cz < dz) ? 5 : (cz > dz) ? 6 : 0;
        if (px == 0 && py == 0 && pz == 0) return {mis, 3'd0};
        if (mis) begin
            if (cz == 0) return {1'b1, 3'd5};
            p = (px != 0) ? px : (py != 0) ? py : pz;
            return {1'b1, 3'(p)};
        end
        if (cls) p = (px != 0) ? px : (py != 0) ? py : pz;
        else     p = (pz != 0) ? pz : (py != 0) ? py : px;
        if (cz == 0 && dz == 0 && p >= 1 && p <= 4 && cg[p] && !cg[5])
            return {1'b1, 3'd5};
        return {1'b0, 3'(p)};
    endfunction

    task automatic step(input int cx, cy, cz, dx, dy, dz, input bit cls, input bit mis);
        @(negedge clk);
        cur_x = XW'(cx); cur_y = YW'(cy); cur_z = ZW'(cz);
        dst_x = XW'(dx); dst_y = YW'(dy); dst_z = ZW'(dz);
        msg_class = cls; mis_in = mis; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Walks one packet hop by hop, feeding each decision back as the next node.
    task automatic walk(input int sx, sy, sz, dx, dy, dz, input bit cls,
                        input logic [6:1] cg, input int exp_hops);
        int cx, cy, cz, hops;
        bit mis, down_seen, bad_turn, step_ok;
        logic [3:0] e;
        cx = sx; cy = sy; cz = sz; hops = 0; mis = 0;
        down_seen = 0; bad_turn = 0; step_ok = 1;
        for (int k = 0; k < 20; k++) begin
            step(cx, cy, cz, dx, dy, dz, cls, mis);
            e = ref_route(cx, cy, cz, dx, dy, dz, cls, mis, cg);
            if (!out_valid || out_port != e[2:0] || out_mis != e[3] || out_vc != cls) begin
                if (step_ok)
                    check(0, cls ? "R4/R5/R9 hop" : "R3/R5/R9 hop",
                          int'(out_port), int'(e[2:0]));
                step_ok = 0;
            end
            if (out_port == 3'd0) break;
            if (down_seen && out_port inside {3'd1, 3'd2, 3'd3, 3'd4}) bad_turn = 1;
            if (mis && out_port == 3'd6) down_seen = 1;
            case (out_port)
                3'd1: cx++;
                3'd2: cx--;
                3'd3: cy++;
                3'd4: cy--;
                3'd5: cz++;
                3'd6: cz--;
                default: ;
            endcase
            mis = out_mis;
            hops++;
        end
        if (step_ok) check(1, "R3/R4 hop", 0, 0);
        check(cx == dx && cy == dy && cz == dz, "R10 arrival", cx*100 + cy*10 + cz,
              dx*100 + dy*10 + dz);
        check(hops == exp_hops, "R10 hop count", hops, exp_hops);
        check(!bad_turn, "R10 planar hop after descent", int'(bad_turn), 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int man;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 0 && out_port == 0 && out_vc == 0 && out_mis == 0,
              "R11 reset", int'({out_valid, out_port, out_vc, out_mis}), 0);
        rst = 1'b0;
        set_cong(6'b0);

        // R1: valid tracks in_valid by one cycle
        step(0, 0, 0, 3, 3, 1, 0, 0);
        check(out_port == 3'd5, "R1 R3 request climbs first", int'(out_port), 5);
        @(negedge clk);
        check(out_valid == 0, "R1 idle after header", int'(out_valid), 0);

        // R2: local port even with flag set and full congestion
        set_cong(6'b111111);
        step(2, 1, 0, 2, 1, 0, 1, 1);
        check(out_port == 3'd0 && out_mis == 1, "R2 local at destination",
              int'(out_port), 0);

        // R6: threshold edge on XP
        set_cong(6'b0);
        cong_thresh = 4'd5;
        port_credits[0 +: CRED_W] = 4'd5;
        step(0, 0, 0, 3, 0, 0, 1, 0);
        check(out_port == 3'd1 && out_mis == 0, "R6 equal to threshold not congested",
              int'(out_port), 1);
        port_credits[0 +: CRED_W] = 4'd4;
        step(0, 0, 0, 3, 0, 0, 1, 0);
        check(out_port == 3'd5 && out_mis == 1, "R6 R7 below threshold diverts",
              int'(out_port), 5);

        // R8: up congested blocks diversion
        set_cong(6'b011111);
        step(0, 0, 0, 3, 0, 0, 1, 0);
        check(out_port == 3'd1 && out_mis == 0, "R8 up congested keeps path",
              int'(out_port), 1);
        // R8: node on layer 1 never diverts
        set_cong(6'b001111);
        step(0, 0, 1, 3, 0, 1, 1, 0);
        check(out_port == 3'd1 && out_mis == 0, "R8 layer 1 no divert", int'(out_port), 1);
        // R8: destination on layer 1 never diverts
        step(0, 0, 0, 3, 0, 1, 1, 0);
        check(out_port == 3'd1 && out_mis == 0, "R8 upper destination no divert",
              int'(out_port), 1);
        // R9: flag set on layer 0 away from destination climbs
        set_cong(6'b0);
        step(1, 1, 0, 3, 2, 0, 0, 1);
        check(out_port == 3'd5 && out_mis == 1, "R9 flagged climbs", int'(out_port), 5);
        // R9: flagged on layer 1 at destination column descends
        step(3, 2, 1, 3, 2, 0, 0, 1);
        check(out_port == 3'd6 && out_mis == 1, "R9 flagged descends", int'(out_port), 6);
        // R4: reply goes x first
        step(0, 0, 1, 2, 2, 0, 1, 0);
        check(out_port == 3'd1 && out_vc == 1, "R4 R5 reply x first", int'(out_port), 1);

        // R3 R4 R10: every pair, both classes, no congestion
        set_cong(6'b0);
        for (int s = 0; s < 32; s++)
            for (int d = 0; d < 32; d++)
                for (int c = 0; c < 2; c++) begin
                    man = iabs(s%4 - d%4) + iabs((s/4)%4 - (d/4)%4) + iabs(s/16 - d/16);
                    walk(s%4, (s/4)%4, s/16, d%4, (d/4)%4, d/16, c[0], 6'b0, man);
                end

        // R7 R9 R10: core-layer pairs with every planar port congested
        set_cong(6'b001111);
        for (int s = 0; s < 16; s++)
            for (int d = 0; d < 16; d++)
                for (int c = 0; c < 2; c++) begin
                    man = iabs(s%4 - d%4) + iabs(s/4 - d/4);
                    walk(s%4, s/4, 0, d%4, d/4, 0, c[0], 6'b001111,
                         (s == d) ? 0 : man + 2);
                end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule